// File: doc/BRIEF.md
# Next Fetch Address Sequencer

This block holds the program counter of a 32-bit single-issue core and decides which address is fetched next. Each enabled cycle it either steps to the next word, or records a redirect target taken from a relative branch, a region jump or a register jump. The instruction word that follows the branch or jump is always fetched and executed before the redirect takes effect.

The decoder supplies a 2-bit next-address select, the branch-condition flag from the ALU, the low 26 bits of the current instruction word and the value read from the source register. The block drives the fetch address straight from its PC register and also drives the return address that a jump-and-link writes into register 31. Decode, the ALU, the register file and the memories sit outside.

Top module: `fetch_seq`

## Requirements
- R1: Reset is synchronous, acts whether or not clock enable is high, loads the PC with 32'hBFC00000 and discards any pending redirect.
- R2: With select 0 and no redirect pending, an enabled cycle advances the PC by 4.
- R3: Select 1 with the condition flag high redirects to PC+4 plus the sign-extended 16-bit immediate (instruction bits [15:0]) shifted left by 2. With the flag low, select 1 behaves like select 0.
- R4: Select 2 redirects to the concatenation of bits [31:28] of PC+4, instruction bits [25:0] and two zero bits.
- R5: Select 3 redirects to the full 32-bit source register value.
- R6: The link output always equals the current fetch address plus 8.
- R7: A redirect does not change the next fetch: the PC first steps to PC+4 (the delay slot), and on the following enabled cycle it loads the target.
- R8: While clock enable is low, the PC and any pending redirect keep their values.
- R9: A redirect presented while a target is already pending (in the delay slot) is ignored; the earlier target is used, and no second redirect follows.
- R10: The fetch address comes only from the PC register; select, flag and operand changes affect it only at a clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| clkEn | input | 1 | Clock enable; low freezes all state |
| jumpField | input | 26 | Instruction bits [25:0]; bits [15:0] are the branch immediate |
| pcSel | input | 2 | Next-address select: 0 step, 1 branch, 2 region jump, 3 register jump |
| brCond | input | 1 | Branch condition flag for select 1 |
| rsValue | input | 32 | Source register value for select 3 |
| fetchAddr | output | 32 | Registered program counter |
| linkValue | output | 32 | Return address, fetch address plus 8 |

## Verification
The bound assertions check every cycle that reset lands on the vector, that a disabled cycle freezes the PC, that stepping, capture of a register-jump target and the delay-slot step land on the right address, and that a pending target is loaded in the next enabled cycle while a second redirect is dropped. Target arithmetic for branches and region jumps, the not-taken branch, survival of a pending target across stalls and its loss on reset are shown by the bench's directed scenarios, which follow full redirect sequences from the ports.

// File: rtl/fetch_seq_pkg.sv
package fetch_seq_pkg;

  typedef enum logic [1:0] {
    SEL_STEP   = 2'd0,
    SEL_BRANCH = 2'd1,
    SEL_REGION = 2'd2,
    SEL_REGJMP = 2'd3
  } nextSel_e;

  // Strobes sent from the control to the datapath each cycle.
  typedef struct packed {
    logic     loadPending;  // PC takes the stored target, pending clears
    logic     capture;      // store a new target and mark it pending
    nextSel_e kind;         // which target the datapath computes
  } seqStrobes_t;

endpackage

// File: rtl/fetch_seq_ctrl.sv
module fetch_seq_ctrl
  import fetch_seq_pkg::*;
(
  input  logic [1:0]  pcSel,
  input  logic        brCond,
  input  logic        pendValid,
  output seqStrobes_t strb
);

  nextSel_e selKind;
  logic     wantRedirect;

  assign selKind = nextSel_e'(pcSel);

  always_comb begin
    unique case (selKind)
      SEL_BRANCH: wantRedirect = brCond;
      SEL_REGION: wantRedirect = 1'b1;
      SEL_REGJMP: wantRedirect = 1'b1;
      default:    wantRedirect = 1'b0;
    endcase
  end

  always_comb begin
    strb.kind        = selKind;
    // An instruction in the delay slot may not start another redirect.
    strb.loadPending = pendValid;
    strb.capture     = wantRedirect & ~pendValid;
  end

endmodule

// File: rtl/fetch_seq_dp.sv
module fetch_seq_dp
  import fetch_seq_pkg::*;
#(
  parameter int              ADDR_W    = 32,
  parameter int              IDX_W     = 26,
  parameter int              IMM_W     = 16,
  parameter logic [ADDR_W-1:0] RESET_VEC = 32'hBFC00000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clkEn,
  input  seqStrobes_t       strb,
  input  logic [IDX_W-1:0]  jumpField,
  input  logic [ADDR_W-1:0] rsValue,
  output logic [ADDR_W-1:0] pcQ,
  output logic [ADDR_W-1:0] pendTarget,
  output logic              pendValid,
  output logic [ADDR_W-1:0] linkValue
);

  localparam int              REGION_W  = ADDR_W - IDX_W - 2;
  localparam int              EXT_W     = ADDR_W - IMM_W - 2;
  localparam logic [ADDR_W-1:0] STEP_B  = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] LINK_B  = ADDR_W'(8);

  logic [ADDR_W-1:0] seqAddr;
  logic [ADDR_W-1:0] brOffset;
  logic [ADDR_W-1:0] branchTgt;
  logic [ADDR_W-1:0] regionTgt;
  logic [ADDR_W-1:0] nextTgt;
  logic [IMM_W-1:0]  imm;

  assign imm       = jumpField[IMM_W-1:0];
  assign seqAddr   = pcQ + STEP_B;
  assign brOffset  = {{EXT_W{imm[IMM_W-1]}}, imm, 2'b00};
  assign branchTgt = seqAddr + brOffset;

  generate
    if (REGION_W > 0) begin : g_region
      assign regionTgt = {seqAddr[ADDR_W-1 -: REGION_W], jumpField, 2'b00};
    end else begin : g_noregion
      assign regionTgt = {jumpField[ADDR_W-3:0], 2'b00};
    end
  endgenerate

  always_comb begin
    unique case (strb.kind)
      SEL_BRANCH: nextTgt = branchTgt;
      SEL_REGION: nextTgt = regionTgt;
      SEL_REGJMP: nextTgt = rsValue;
      default:    nextTgt = seqAddr;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pcQ        <= RESET_VEC;
      pendValid  <= 1'b0;
      pendTarget <= '0;
    end else if (clkEn) begin
      if (strb.loadPending) begin
        pcQ       <= pendTarget;
        pendValid <= 1'b0;
      end else begin
        pcQ <= seqAddr;
        if (strb.capture) begin
          pendTarget <= nextTgt;
          pendValid  <= 1'b1;
        end
      end
    end
  end

  assign linkValue = pcQ + LINK_B;

endmodule

// File: rtl/fetch_seq.sv
module fetch_seq
  import fetch_seq_pkg::*;
#(
  parameter int              ADDR_W    = 32,
  parameter int              IDX_W     = 26,
  parameter int              IMM_W     = 16,
  parameter logic [ADDR_W-1:0] RESET_VEC = 32'hBFC00000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clkEn,
  input  logic [IDX_W-1:0]  jumpField,
  input  logic [1:0]        pcSel,
  input  logic              brCond,
  input  logic [ADDR_W-1:0] rsValue,
  output logic [ADDR_W-1:0] fetchAddr,
  output logic [ADDR_W-1:0] linkValue
);

  seqStrobes_t       strb;
  logic              pendValid;
  logic [ADDR_W-1:0] pendTarget;

  fetch_seq_ctrl u_ctrl (
    .pcSel     (pcSel),
    .brCond    (brCond),
    .pendValid (pendValid),
    .strb      (strb)
  );

  fetch_seq_dp #(
    .ADDR_W    (ADDR_W),
    .IDX_W     (IDX_W),
    .IMM_W     (IMM_W),
    .RESET_VEC (RESET_VEC)
  ) u_dp (
    .clk        (clk),
    .rst        (rst),
    .clkEn      (clkEn),
    .strb       (strb),
    .jumpField  (jumpField),
    .rsValue    (rsValue),
    .pcQ        (fetchAddr),
    .pendTarget (pendTarget),
    .pendValid  (pendValid),
    .linkValue  (linkValue)
  );

endmodule

// File: rtl/fetch_seq_chk.sv
module fetch_seq_chk #(
  parameter int              ADDR_W    = 32,
  parameter logic [ADDR_W-1:0] RESET_VEC = 32'hBFC00000
) (
  input logic              clk,
  input logic              rst,
  input logic              clkEn,
  input logic [1:0]        pcSel,
  input logic [ADDR_W-1:0] rsValue,
  input logic [ADDR_W-1:0] fetchAddr,
  input logic [ADDR_W-1:0] linkValue,
  input logic              pendValid,
  input logic [ADDR_W-1:0] pendTarget
);

  // R1: reset lands on the vector with nothing pending
  p_reset_vec_r1: assert property (@(posedge clk)
    rst |=> (fetchAddr == RESET_VEC) && !pendValid);

  // R2: plain step
  p_step_r2: assert property (@(posedge clk) disable iff (rst)
    (clkEn && !pendValid && pcSel == 2'd0) |=> fetchAddr == $past(fetchAddr) + ADDR_W'(4));

  // R5: register jump captures the operand
  p_regjump_r5: assert property (@(posedge clk) disable iff (rst)
    (clkEn && !pendValid && pcSel == 2'd3) |=> pendValid && pendTarget == $past(rsValue));

  // R6: link tracks a step of the PC
  p_link_r6: assert property (@(posedge clk) disable iff (rst)
    (clkEn && !pendValid && pcSel == 2'd0) |=> linkValue == $past(linkValue) + ADDR_W'(4));

  // R7: a jump still fetches the delay slot next
  p_delay_r7: assert property (@(posedge clk) disable iff (rst)
    (clkEn && !pendValid && pcSel == 2'd2) |=> fetchAddr == $past(fetchAddr) + ADDR_W'(4));

  // R8: stall freezes PC and pending state
  p_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !clkEn |=> $stable(fetchAddr) && $stable(pendValid) && $stable(pendTarget));

  // R9: pending target wins, no second redirect survives
  p_first_wins_r9: assert property (@(posedge clk) disable iff (rst)
    (clkEn && pendValid) |=> fetchAddr == $past(pendTarget) && !pendValid);

endmodule

bind fetch_seq fetch_seq_chk #(
  .ADDR_W    (ADDR_W),
  .RESET_VEC (RESET_VEC)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .clkEn      (clkEn),
  .pcSel      (pcSel),
  .rsValue    (rsValue),
  .fetchAddr  (fetchAddr),
  .linkValue  (linkValue),
  .pendValid  (pendValid),
  .pendTarget (pendTarget)
);

// File: tb/fetch_seq_tb.sv
module fetch_seq_tb;

  localparam logic [31:0] VEC = 32'hBFC00000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        clkEn = 1'b1;
  logic [25:0] jumpField = '0;
  logic [1:0]  pcSel = 2'd0;
  logic        brCond = 1'b0;
  logic [31:0] rsValue = '0;
  logic [31:0] fetchAddr;
  logic [31:0] linkValue;

  int nChecks = 0;
  int nFails  = 0;

  always #10 clk = ~clk;  // 50 MHz

  fetch_seq u_dut (
    .clk       (clk),
    .rst       (rst),
    .clkEn     (clkEn),
    .jumpField (jumpField),
    .pcSel     (pcSel),
    .brCond    (brCond),
    .rsValue   (rsValue),
    .fetchAddr (fetchAddr),
    .linkValue (linkValue)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Inputs change 1 ns after the edge; outputs are read there too.
  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic idle();
    pcSel = 2'd0; brCond = 1'b0; clkEn = 1'b1;
  endtask

  task automatic t_reset();
    rst = 1'b1; step(); step();
    chk("R1 reset vector", fetchAddr, VEC);
    chk("R6 link at reset", linkValue, VEC + 32'd8);
    rst = 1'b0;
  endtask

  task automatic t_step();
    logic [31:0] p = fetchAddr;
    idle(); step();
    chk("R2 step", fetchAddr, p + 32'd4);
    step();
    chk("R2 second step", fetchAddr, p + 32'd8);
    chk("R6 link follows", linkValue, p + 32'd16);
  endtask

  task automatic t_branch();
    logic [31:0] p = fetchAddr;
    jumpField = 26'h000FFFE;  // imm -2
    pcSel = 2'd1; brCond = 1'b1; step();
    chk("R7 branch delay slot", fetchAddr, p + 32'd4);
    idle(); step();
    chk("R3 backward branch target", fetchAddr, p - 32'd4);
    p = fetchAddr;
    jumpField = 26'h0000010;  // imm +16
    pcSel = 2'd1; brCond = 1'b1; step();
    idle(); step();
    chk("R3 forward branch target", fetchAddr, p + 32'd4 + 32'd64);
    p = fetchAddr;
    pcSel = 2'd1; brCond = 1'b0; step();
    chk("R3 not taken", fetchAddr, p + 32'd4);
    idle(); step();
    chk("R3 not taken no redirect", fetchAddr, p + 32'd8);
  endtask

  task automatic t_region();
    logic [31:0] p = fetchAddr;
    logic [31:0] s = p + 32'd4;
    jumpField = 26'h2345678;
    pcSel = 2'd2; step();
    chk("R7 jump delay slot", fetchAddr, p + 32'd4);
    idle(); step();
    chk("R4 region target", fetchAddr, {s[31:28], 26'h2345678, 2'b00});
  endtask

  task automatic t_regjump();
    rsValue = 32'h8000_1000;
    pcSel = 2'd3; step();
    rsValue = 32'h0;
    idle(); step();
    chk("R5 register target", fetchAddr, 32'h8000_1000);
    chk("R6 link after jump", linkValue, 32'h8000_1008);
  endtask

  task automatic t_ignore();
    logic [31:0] p = fetchAddr;
    rsValue = 32'h0000_4000;
    pcSel = 2'd3; step();
    chk("R9 first jump delay slot", fetchAddr, p + 32'd4);
    jumpField = 26'h0000100;
    pcSel = 2'd2; step();
    chk("R9 first target wins", fetchAddr, 32'h0000_4000);
    idle(); step();
    chk("R9 second redirect dropped", fetchAddr, 32'h0000_4004);
  endtask

  task automatic t_hold();
    logic [31:0] p = fetchAddr;
    rsValue = 32'h0001_2340;
    pcSel = 2'd3; clkEn = 1'b0;
    step(); step(); step();
    chk("R8 PC held", fetchAddr, p);
    clkEn = 1'b1; step();
    chk("R8 enabled jump slot", fetchAddr, p + 32'd4);
    pcSel = 2'd0; clkEn = 1'b0; step(); step();
    chk("R8 held in slot", fetchAddr, p + 32'd4);
    clkEn = 1'b1; step();
    chk("R8 pending kept through stall", fetchAddr, 32'h0001_2340);
  endtask

  task automatic t_comb();
    logic [31:0] p = fetchAddr;
    @(negedge clk);
    pcSel = 2'd3; rsValue = 32'hDEAD_0000; brCond = 1'b1; jumpField = 26'h3FFFFFF;
    #2;
    chk("R10 no comb path", fetchAddr, p);
    idle(); step(); step();
  endtask

  task automatic t_reset_clears();
    rsValue = 32'h0000_8000;
    pcSel = 2'd3; step();
    rst = 1'b1; clkEn = 1'b0; pcSel = 2'd0; step();
    chk("R1 reset while stalled", fetchAddr, VEC);
    rst = 1'b0; clkEn = 1'b1; step();
    chk("R1 pending cleared", fetchAddr, VEC + 32'd4);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  endtask

  initial begin
    #1;
    t_reset();
    t_step();
    t_branch();
    t_region();
    t_regjump();
    t_ignore();
    t_hold();
    t_comb();
    t_reset_clears();
    finish_run();
  end

  initial begin
    #(20 * 200000);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

endmodule